// File: doc/BRIEF.md
# UART Receive Buffer

This block holds characters that a serial deserializer has already assembled, until the processor collects them. Each slot keeps an 8-bit character together with four error bits (framing, parity, break, overrun). The buffer is a circular store addressed by a read pointer and an occupancy count. The next free slot is always the read pointer plus the count, wrapped at the depth. A line-control write selects buffered mode, which uses all 16 slots, or single-character mode, which uses one slot. The mode can change at runtime, and each change empties the buffer.

A data read presents the oldest entry as one 12-bit word: error bits above the character. The same read moves that entry's error bits into a receive status register. The processor can clear that register with a separate strobe. The block keeps the receive-empty and receive-full bits of the flag byte. It also raises a one-cycle receive event when a push brings the buffer up to the trigger level. The trigger level is one, so the event fires on the first character that enters an empty buffer.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset, `flags` is 0x90, `rx_event` is 0, `rsr_val` is 0, single-character mode is selected and `push_ready` is 1.
- R2: Accepted entries come back in arrival order. `rd_data` carries the character in bits 7:0 and the error bits in bits 11:8: framing in bit 8, parity in bit 9, break in bit 10 and overrun in bit 11.
- R3: `push_ready` is 1 only while the count is below 16 in buffered mode, or below 1 in single-character mode. A push while `push_ready` is 0 is dropped and leaves every state unchanged.
- R4: Buffered mode is bit 4 of `lcr_wdata`. An `lcr_wr` that changes this bit resets the count and the read pointer to zero, so the flags report empty. A push or read in the same cycle has no effect on count or pointer. An `lcr_wr` that does not change the bit has no effect.
- R5: In `flags`, bit 7 (transmit empty) is always 1. Bit 5 (transmit full) and bits 3:0 are always 0.
- R6: `flags` bit 6 (receive full) is 1 exactly when the count equals the mode's capacity, so it clears after any read that removes an entry. `flags` bit 4 (receive empty) is 1 exactly when the count is zero.
- R7: A read of an empty buffer returns the entry stored at the read pointer and moves neither the pointer nor the count.
- R8: Every data read, including a read of an empty buffer, loads `rsr_val` with bits 11:8 of the returned entry. `rsr_clr` sets `rsr_val` to zero. A read in the same cycle takes precedence over the clear.
- R9: A push with `push_brk` high stores the value 0x400 (break bit set, character zero), whatever is on `push_char` and `push_err`.
- R10: `rx_event` is high for exactly one cycle, the cycle after an accepted push into a buffer that held trigger-level-minus-one entries (zero entries by default).
- R11: A push and a read in the same cycle on a non-empty buffer that is not full both take effect: the oldest entry is returned and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Deserializer offers one entry |
| push_char | input | 8 | Received character |
| push_err | input | 4 | Error bits: framing, parity, break, overrun (LSB first) |
| push_brk | input | 1 | Entry is a line break |
| push_ready | output | 1 | Buffer can accept a push this cycle |
| lcr_wr | input | 1 | Line-control write strobe |
| lcr_wdata | input | 8 | Line-control write value; bit 4 selects buffered mode |
| rd_stb | input | 1 | Processor data read strobe |
| rd_data | output | 12 | Entry at the read pointer |
| rsr_clr | input | 1 | Processor write to the receive status register |
| rsr_val | output | 4 | Receive status register |
| flags | output | 8 | Flag byte |
| rx_event | output | 1 | Receive level event pulse |

## Verification
The assertions assume that each strobe is a clean one-cycle-per-operation input, sampled only at the rising edge. They also assume that a line-control write, a push and a read can all arrive in the same cycle, and that the mode toggle then overrides the other two. The bench drives every input just after the falling edge and holds it for a full cycle. It mixes rare mode toggles with dense pushes and reads, so the buffer reaches full, empty and simultaneous push-and-read states in both modes.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    localparam int CHAR_W       = 8;
    localparam int ERR_W        = 4;
    localparam int ENTRY_W      = CHAR_W + ERR_W;
    localparam int MODE_BIT     = 4;
    localparam int ERR_BRK_IDX  = 2;
    localparam int FLG_TX_EMPTY = 7;
    localparam int FLG_RX_FULL  = 6;
    localparam int FLG_TX_FULL  = 5;
    localparam int FLG_RX_EMPTY = 4;

    typedef logic [ENTRY_W-1:0] entry_t;
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
    parameter int DEPTH = 16,
    parameter int W     = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data)); // R2
endmodule

// File: rtl/rxb_status.sv
module rxb_status #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ERR_W-1:0] load_val,
    input  logic             clr,
    output logic [ERR_W-1:0] st
);
    logic [ERR_W-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d = load_val;
        end else if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;

    AST_STATUS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !load) |=> st_q == '0); // R8
    AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> st_q == $past(load_val)); // R8
endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl #(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    parameter int MODE_BIT = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic          lcr_wr,
    input  logic [7:0]    lcr_wdata,
    input  logic          rd_stb,
    output logic          push_ready,
    output logic          wr_en,
    output logic [AW-1:0] wr_slot,
    output logic [AW-1:0] rd_ptr,
    output logic          rx_empty,
    output logic          rx_full,
    output logic          rx_event
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [CW-1:0] cnt;
        logic          mode;
        logic          empty;
        logic          full;
        logic          event_hit;
    } state_t;

    state_t s_d, s_q;

    logic          toggle;
    logic [CW-1:0] cap_q;
    logic [CW-1:0] cap_d;
    logic          acc;
    logic          pop;
    logic [CW:0]   slot_sum;
    logic [CW:0]   ptr_sum;

    always_comb begin
        toggle   = lcr_wr && (lcr_wdata[MODE_BIT] != s_q.mode);
        cap_q    = s_q.mode ? CW'(DEPTH) : CW'(1);
        acc      = push_valid && (s_q.cnt < cap_q) && !toggle;
        pop      = rd_stb && (s_q.cnt != '0) && !toggle;

        slot_sum = (CW+1)'(s_q.ptr) + (CW+1)'(s_q.cnt);
        if (slot_sum >= (CW+1)'(DEPTH)) slot_sum = slot_sum - (CW+1)'(DEPTH);
        ptr_sum  = (CW+1)'(s_q.ptr) + (CW+1)'(1);
        if (ptr_sum >= (CW+1)'(DEPTH)) ptr_sum = '0;

        s_d = s_q;
        s_d.event_hit = acc && (s_q.cnt == CW'(TRIG - 1));
        if (toggle) begin
            s_d.mode = lcr_wdata[MODE_BIT];
            s_d.ptr  = '0;
            s_d.cnt  = '0;
        end else begin
            if (pop) s_d.ptr = AW'(ptr_sum);
            s_d.cnt = s_q.cnt + CW'(acc) - CW'(pop);
        end
        cap_d   = s_d.mode ? CW'(DEPTH) : CW'(1);
        s_d.empty = (s_d.cnt == '0);
        s_d.full  = (s_d.cnt == cap_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ptr       <= '0;
            s_q.cnt       <= '0;
            s_q.mode      <= 1'b0;
            s_q.empty     <= 1'b1;
            s_q.full      <= 1'b0;
            s_q.event_hit <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign push_ready = s_q.cnt < cap_q;
    assign wr_en      = acc;
    assign wr_slot    = AW'(slot_sum);
    assign rd_ptr     = s_q.ptr;
    assign rx_empty   = s_q.empty;
    assign rx_full    = s_q.full;
    assign rx_event   = s_q.event_hit;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= cap_q); // R3
    AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ready && !rd_stb && !lcr_wr) |=> $stable(s_q.cnt) && $stable(s_q.ptr)); // R3
    AST_TOGGLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> (s_q.cnt == '0) && (s_q.ptr == '0) && rx_empty); // R4
    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rx_empty && !push_valid && !lcr_wr) |=> $stable(s_q.ptr) && rx_empty); // R7
    AST_FULL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rd_stb && !lcr_wr) |=> !rx_full); // R6
    AST_EVENT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready && !toggle && s_q.cnt == CW'(TRIG - 1)) |=> rx_event); // R10
    AST_EVENT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_event |-> !$past(rx_event)); // R10
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import rxb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TRIG  = 1,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_valid,
    input  logic [CHAR_W-1:0]   push_char,
    input  logic [ERR_W-1:0]    push_err,
    input  logic                push_brk,
    output logic                push_ready,
    input  logic                lcr_wr,
    input  logic [7:0]          lcr_wdata,
    input  logic                rd_stb,
    output logic [ENTRY_W-1:0]  rd_data,
    input  logic                rsr_clr,
    output logic [ERR_W-1:0]    rsr_val,
    output logic [7:0]          flags,
    output logic                rx_event
);
    entry_t        push_entry;
    logic          wr_en;
    logic [AW-1:0] wr_slot;
    logic [AW-1:0] rd_ptr;
    logic          rx_empty;
    logic          rx_full;

    always_comb begin
        if (push_brk) begin
            push_entry = '0;
            push_entry[CHAR_W + ERR_BRK_IDX] = 1'b1;
        end else begin
            push_entry = {push_err, push_char};
        end
    end

    rxb_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG), .MODE_BIT(MODE_BIT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .lcr_wr     (lcr_wr),
        .lcr_wdata  (lcr_wdata),
        .rd_stb     (rd_stb),
        .push_ready (push_ready),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .rd_ptr     (rd_ptr),
        .rx_empty   (rx_empty),
        .rx_full    (rx_full),
        .rx_event   (rx_event)
    );

    rxb_store #(.DEPTH(DEPTH), .W(ENTRY_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_slot),
        .wr_data (push_entry),
        .rd_addr (rd_ptr),
        .rd_data (rd_data)
    );

    rxb_status #(.ERR_W(ERR_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rd_stb),
        .load_val (rd_data[ENTRY_W-1:CHAR_W]),
        .clr      (rsr_clr),
        .st       (rsr_val)
    );

    always_comb begin
        flags               = '0;
        flags[FLG_TX_EMPTY] = 1'b1;
        flags[FLG_TX_FULL]  = 1'b0;
        flags[FLG_RX_FULL]  = rx_full;
        flags[FLG_RX_EMPTY] = rx_empty;
    end

    AST_BRK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && push_brk) |-> (push_entry == entry_t'(12'h400))); // R9
    AST_FLAG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags[FLG_RX_FULL] && flags[FLG_RX_EMPTY])); // R6
endmodule

// File: tb/sim_uart_rx_buffer.sv
`timescale 1ns/1ps
module sim_uart_rx_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [7:0]  push_char = '0;
    logic [3:0]  push_err = '0;
    logic        push_brk = 1'b0;
    logic        push_ready;
    logic        lcr_wr = 1'b0;
    logic [7:0]  lcr_wdata = '0;
    logic        rd_stb = 1'b0;
    logic [11:0] rd_data;
    logic        rsr_clr = 1'b0;
    logic [3:0]  rsr_val;
    logic [7:0]  flags;
    logic        rx_event;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [11:0] m_mem [16];
    int          m_ptr = 0;
    int          m_cnt = 0;
    bit          m_mode = 0;
    logic [3:0]  m_st = '0;
    bit          m_ev = 0;
    logic [11:0] last_rd;

    always #2 clk = ~clk;

    uart_rx_buffer u0 (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_char(push_char),
        .push_err(push_err), .push_brk(push_brk), .push_ready(push_ready),
        .lcr_wr(lcr_wr), .lcr_wdata(lcr_wdata), .rd_stb(rd_stb), .rd_data(rd_data),
        .rsr_clr(rsr_clr), .rsr_val(rsr_val), .flags(flags), .rx_event(rx_event)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int cap_of(bit mode);
        return mode ? 16 : 1;
    endfunction

    function automatic logic [7:0] exp_flags(int cnt, bit mode);
        logic [7:0] f = 8'h80;
        if (cnt == 0) f[4] = 1'b1;
        if (cnt == cap_of(mode)) f[6] = 1'b1;
        return f;
    endfunction

    task automatic cycle(bit p, logic [7:0] ch, logic [3:0] er, bit brk,
                         bit rd, bit clr, bit lw, logic [7:0] lv);
        bit tog;
        bit acc;
        bit pop;
        logic [11:0] ent;
        push_valid = p; push_char = ch; push_err = er; push_brk = brk;
        rd_stb = rd; rsr_clr = clr; lcr_wr = lw; lcr_wdata = lv;
        #1;
        last_rd = rd_data;
        if (rd) chk(m_cnt == 0 ? "R7 empty read data" : "R2 read data", rd_data, m_mem[m_ptr]);
        tog = lw && (lv[4] != m_mode);
        ent = brk ? 12'h400 : {er, ch};
        if (rd) m_st = m_mem[m_ptr][11:8];
        else if (clr) m_st = '0;
        m_ev = 0;
        if (tog) begin
            m_mode = lv[4]; m_cnt = 0; m_ptr = 0;
        end else begin
            acc = p && (m_cnt < cap_of(m_mode));
            pop = rd && (m_cnt > 0);
            m_ev = acc && (m_cnt == 0);
            if (acc) m_mem[(m_ptr + m_cnt) % 16] = ent;
            if (pop) m_ptr = (m_ptr + 1) % 16;
            m_cnt = m_cnt + int'(acc) - int'(pop);
        end
        @(posedge clk);
        @(negedge clk);
        chk("R6 receive flags", flags & 8'h50, exp_flags(m_cnt, m_mode) & 8'h50);
        chk("R5 fixed flag bits", flags & 8'hAF, 8'h80);
        chk("R3 push_ready", push_ready, (m_cnt < cap_of(m_mode)) ? 1 : 0);
        chk("R10 rx_event", rx_event, m_ev ? 1 : 0);
        chk("R8 status", rsr_val, m_st);
    endtask

    task automatic idle();
        cycle(0, 8'h00, 4'h0, 0, 0, 0, 0, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset flags", flags, 8'h90);
        chk("R1 reset event", rx_event, 0);
        chk("R1 reset status", rsr_val, 0);
        chk("R1 reset ready", push_ready, 1);
        @(negedge clk);

        // R4: enter buffered mode
        cycle(0, 0, 0, 0, 0, 0, 1, 8'h10);
        // R3: fill sixteen, seventeenth dropped
        for (int i = 0; i < 17; i++) cycle(1, 8'(i + 8'h41), 4'(i), 0, 0, 0, 0, 8'h10);
        chk("R6 full after sixteen", flags[6], 1);
        for (int i = 0; i < 16; i++) cycle(0, 0, 0, 0, 1, 0, 0, 8'h10);
        // R7: empty read
        cycle(0, 0, 0, 0, 1, 0, 0, 8'h10);
        chk("R7 still empty", flags[4], 1);
        // R9: break entry
        cycle(1, 8'hFF, 4'hB, 1, 0, 0, 0, 8'h10);
        cycle(0, 0, 0, 0, 1, 0, 0, 8'h10);
        chk("R9 break value", last_rd, 12'h400);
        chk("R8 status after break", rsr_val, 4'h4);
        cycle(0, 0, 0, 0, 0, 1, 0, 8'h10);
        chk("R8 status cleared", rsr_val, 0);
        // R11: simultaneous push and read
        cycle(1, 8'h31, 4'h1, 0, 0, 0, 0, 8'h10);
        cycle(1, 8'h32, 4'h2, 0, 1, 0, 0, 8'h10);
        chk("R11 returned oldest", last_rd, 12'h131);
        chk("R11 count kept", flags[4], 0);
        // R4: non-toggling write ignored, toggle beats push
        cycle(0, 0, 0, 0, 0, 0, 1, 8'h10);
        chk("R4 same-mode write kept entry", flags[4], 0);
        cycle(1, 8'h55, 4'h0, 0, 0, 0, 1, 8'h00);
        chk("R4 toggle emptied", flags, 8'h90);
        // single-character mode
        cycle(1, 8'h61, 4'h8, 0, 0, 0, 0, 8'h00);
        chk("R6 single full", flags[6], 1);
        cycle(1, 8'h62, 4'h0, 0, 0, 0, 0, 8'h00);
        cycle(0, 0, 0, 0, 1, 0, 0, 8'h00);
        chk("R3 dropped push kept first", last_rd, 12'h861);

        // constrained random
        for (int n = 0; n < 6000; n++) begin
            bit lw = ($urandom_range(0, 99) < 2);
            bit md = (n % 1500) < 1000;
            cycle($urandom_range(0, 99) < 55, 8'($urandom), 4'($urandom),
                  $urandom_range(0, 9) == 0, $urandom_range(0, 99) < 40,
                  $urandom_range(0, 99) < 5, lw, lw ? {3'b000, ~md, 4'h0} : {3'b000, md, 4'h0});
        end
        idle();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule